// File: doc/BRIEF.md
# FEC Correction Statistics Counters

This block keeps running statistics of the bit corrections made by a bank of parallel forward-error-correction decoders. In every clock cycle each decoder reports two small counts: how many received zeros it flipped to one, and how many received ones it flipped to zero. From that single set of reports the block updates seven saturating counters at once. Two counters split the corrections by polarity across the whole bank. One counter holds the grand total. There is one counter per decoder.

Counting runs only while the enhanced correction mode input is high. Software reads each wide counter as two half-width words. Reading the low word snapshots the high word into a per-counter holding register and restarts the counter, so the high word read afterwards belongs to the same value. Corrections reported in the same cycle as the low-word read are not lost. They become the counter's new contents.

Top module: `fec_corr_stats`

## Requirements
- R1: After reset every counter and every holding register is zero and `rd_vld` is low.
- R2: While `enh_mode` is 0 no counter changes, except for the clear caused by a low-word read.
- R3: Counter index 0 adds, each enabled cycle, the sum of the four 4-bit zero-to-one fields in `zero_fix`. Decoder d (d = 1..4) uses bits [4d-1:4d-4].
- R4: Counter index 1 adds, each enabled cycle, the sum of the four 4-bit one-to-zero fields in `one_fix`, with the same field layout.
- R5: Counter index 2 adds, each enabled cycle, the sum of all eight fields of both inputs.
- R6: Counter index 2+d (indices 3..6) adds, each enabled cycle, decoder d's zero field plus its one field. Decoder 4 is the last one.
- R7: `rd_addr[3:1]` selects the counter and `rd_addr[0]` selects the half (0 low, 1 high). `rd_data` and `rd_vld` appear one cycle after `rd_en`. Counter index 7 reads as zero and has no effect.
- R8: A low-word read returns bits [15:0] of the counter as it was before that cycle's update, and copies bits [31:16] into the holding register. A high-word read returns the holding register.
- R9: A low-word read clears the counter. If counting is enabled, that cycle's increment becomes the new value.
- R10: A counter that would pass all ones stays at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enh_mode | input | 1 | Counting enable (enhanced correction mode) |
| zero_fix | input | 16 | Per-decoder zero-to-one correction counts, 4 bits each |
| one_fix | input | 16 | Per-decoder one-to-zero correction counts, 4 bits each |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | Counter index and half select |
| rd_data | output | 16 | Read data |
| rd_vld | output | 1 | Read data valid |

## Verification
Read data and its valid flag are due exactly one rising edge after the strobe. A correction report presented in cycle t is folded into the counter at the same edge, so it shows only in reads issued in cycle t+1 or later. A low-word read in cycle t still returns the value from before that edge. The bench drives inputs and samples outputs on the falling edge. Its reference model advances once per drive, and each sample is compared with the value the model predicted at the previous falling edge. A narrow second instance drives counters into saturation within the run.

// File: rtl/fec_stat_pkg.sv
package fec_stat_pkg;
  // counter slot indices; per-decoder counters follow the fixed ones
  localparam int unsigned SLOT_ZERO  = 0;
  localparam int unsigned SLOT_ONE   = 1;
  localparam int unsigned SLOT_TOTAL = 2;
  localparam int unsigned SLOT_DEC0  = 3;

  function automatic int unsigned inc_width(input int unsigned ndec, input int unsigned cw);
    return cw + 1 + $clog2(ndec);
  endfunction
endpackage

// File: rtl/fec_corr_sum.sv
module fec_corr_sum #(
  parameter int unsigned NDEC = 4,
  parameter int unsigned CW   = 4,
  parameter int unsigned IW   = 8
) (
  input  logic [NDEC*CW-1:0]        zero_flat,
  input  logic [NDEC*CW-1:0]        one_flat,
  output logic [IW-1:0]             inc_zero,
  output logic [IW-1:0]             inc_one,
  output logic [IW-1:0]             inc_total,
  output logic [NDEC-1:0][IW-1:0]   inc_dec
);
  localparam int unsigned PAD = IW - CW;

  always_comb begin
    inc_zero = '0;
    inc_one  = '0;
    for (int i = 0; i < NDEC; i++) begin
      inc_zero   = inc_zero + {{PAD{1'b0}}, zero_flat[i*CW +: CW]};
      inc_one    = inc_one  + {{PAD{1'b0}}, one_flat[i*CW +: CW]};
      inc_dec[i] = {{PAD{1'b0}}, zero_flat[i*CW +: CW]}
                 + {{PAD{1'b0}}, one_flat[i*CW +: CW]};
    end
    inc_total = inc_zero + inc_one;
  end
endmodule

// File: rtl/fec_sat_counter.sv
module fec_sat_counter #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned IW    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cnt_en,
  input  logic                 clr,
  input  logic [IW-1:0]        inc,
  output logic [CNT_W/2-1:0]   lo_q,
  output logic [CNT_W/2-1:0]   hold_q
);
  localparam int unsigned HALF = CNT_W / 2;
  localparam int unsigned PAD  = CNT_W + 1 - IW;

  logic [CNT_W-1:0] cnt_q, cnt_d, base;
  logic [CNT_W:0]   sum;
  logic             cnt_upd;

  always_comb begin
    base    = clr ? '0 : cnt_q;
    sum     = {1'b0, base} + {{PAD{1'b0}}, inc};
    cnt_upd = cnt_en | clr;
    if (!cnt_en)
      cnt_d = base;
    else if (sum[CNT_W])
      cnt_d = '1;
    else
      cnt_d = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_upd)
      cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hold_q <= '0;
    else if (clr)
      hold_q <= cnt_q[CNT_W-1:HALF];
  end

  assign lo_q = cnt_q[HALF-1:0];

  // R10
  sat_stick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '1 && cnt_en && !clr) |=> cnt_q == '1);
  // R2
  idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !clr) |=> $stable(cnt_q));
  // R9
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !cnt_en) |=> cnt_q == '0);
  // R8
  hold_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> hold_q == $past(cnt_q[CNT_W-1:HALF]));
endmodule

// File: rtl/fec_corr_regif.sv
module fec_corr_regif #(
  parameter int unsigned NCTR = 7,
  parameter int unsigned HALF = 16,
  parameter int unsigned AW   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_en,
  input  logic [AW-1:0]              rd_addr,
  input  logic [NCTR-1:0][HALF-1:0]  lo_in,
  input  logic [NCTR-1:0][HALF-1:0]  hold_in,
  output logic [NCTR-1:0]            clr_vec,
  output logic [HALF-1:0]            rd_data,
  output logic                       rd_vld
);
  localparam int unsigned IXW = AW - 1;
  localparam logic [IXW-1:0] LAST_IX = IXW'(NCTR - 1);

  logic [IXW-1:0]  idx;
  logic            hit;
  logic [HALF-1:0] data_d;

  always_comb begin
    idx     = rd_addr[AW-1:1];
    hit     = (idx <= LAST_IX);
    data_d  = '0;
    clr_vec = '0;
    if (rd_en && hit)
      data_d = rd_addr[0] ? hold_in[idx] : lo_in[idx];
    for (int k = 0; k < NCTR; k++)
      clr_vec[k] = rd_en && !rd_addr[0] && (idx == IXW'(k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_vld  <= 1'b0;
    end else begin
      rd_vld <= rd_en;
      if (rd_en)
        rd_data <= data_d;
    end
  end

  // R7
  rd_vld_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_vld);
  // R7
  rd_vld_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_vld);
  // R7
  bad_ix_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit) |=> rd_data == '0);
endmodule

// File: rtl/fec_corr_stats.sv
module fec_corr_stats #(
  parameter int unsigned NDEC  = 4,
  parameter int unsigned CW    = 4,
  parameter int unsigned CNT_W = 32
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   enh_mode,
  input  logic [NDEC*CW-1:0]                     zero_fix,
  input  logic [NDEC*CW-1:0]                     one_fix,
  input  logic                                   rd_en,
  input  logic [$clog2(3+NDEC)+1-1:0]            rd_addr,
  output logic [CNT_W/2-1:0]                     rd_data,
  output logic                                   rd_vld
);
  import fec_stat_pkg::*;

  localparam int unsigned NCTR = SLOT_DEC0 + NDEC;
  localparam int unsigned HALF = CNT_W / 2;
  localparam int unsigned AW   = $clog2(NCTR) + 1;
  localparam int unsigned IW   = inc_width(NDEC, CW);

  logic [IW-1:0]            inc_zero, inc_one, inc_total;
  logic [NDEC-1:0][IW-1:0]  inc_dec;
  logic [NCTR-1:0][IW-1:0]  inc_sel;
  logic [NCTR-1:0][HALF-1:0] lo_w, hold_w;
  logic [NCTR-1:0]          clr_w;

  fec_corr_sum #(.NDEC(NDEC), .CW(CW), .IW(IW)) u_sum (
    .zero_flat (zero_fix),
    .one_flat  (one_fix),
    .inc_zero  (inc_zero),
    .inc_one   (inc_one),
    .inc_total (inc_total),
    .inc_dec   (inc_dec)
  );

  for (genvar k = 0; k < NCTR; k++) begin : g_ctr
    if (k == SLOT_ZERO) begin : g_z
      assign inc_sel[k] = inc_zero;
    end else if (k == SLOT_ONE) begin : g_o
      assign inc_sel[k] = inc_one;
    end else if (k == SLOT_TOTAL) begin : g_t
      assign inc_sel[k] = inc_total;
    end else begin : g_d
      assign inc_sel[k] = inc_dec[k-SLOT_DEC0];
    end

    fec_sat_counter #(.CNT_W(CNT_W), .IW(IW)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt_en (enh_mode),
      .clr    (clr_w[k]),
      .inc    (inc_sel[k]),
      .lo_q   (lo_w[k]),
      .hold_q (hold_w[k])
    );
  end

  fec_corr_regif #(.NCTR(NCTR), .HALF(HALF), .AW(AW)) u_regif (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .lo_in   (lo_w),
    .hold_in (hold_w),
    .clr_vec (clr_w),
    .rd_data (rd_data),
    .rd_vld  (rd_vld)
  );

  // R5
  total_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_total == inc_sel[SLOT_ZERO] + inc_sel[SLOT_ONE]);
endmodule

// File: tb/sim_fec_corr_stats.sv
module sim_fec_corr_stats;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enh_mode = 1'b0;
  logic [15:0] zero_fix = '0, one_fix = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data0;
  logic [5:0]  rd_data1;
  logic        rd_vld0, rd_vld1;

  always #10 clk = ~clk;

  fec_corr_stats u0 (.clk(clk), .rst_n(rst_n), .enh_mode(enh_mode), .zero_fix(zero_fix),
    .one_fix(one_fix), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data0), .rd_vld(rd_vld0));
  fec_corr_stats #(.CNT_W(12)) u1 (.clk(clk), .rst_n(rst_n), .enh_mode(enh_mode),
    .zero_fix(zero_fix), .one_fix(one_fix), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data1), .rd_vld(rd_vld1));

  int total = 0, bad = 0;
  bit done = 0;
  longint m0[7], h0[7], m1[7], h1[7];
  longint e0 = 0, e1 = 0;
  bit     ev = 0;
  string  etag = "R1";
  localparam longint MAX0 = 64'hFFFF_FFFF, MAX1 = 4095;

  function automatic string tag_of(logic [3:0] ad);
    int c = int'(ad[3:1]);
    if (c > 6) return "R7";
    if (ad[0]) return "R8";
    if (c == 0) return "R3";
    if (c == 1) return "R4";
    if (c == 2) return "R5";
    return "R6";
  endfunction

  task automatic check_out();
    total++;
    if (rd_vld0 !== ev || rd_vld1 !== ev) begin
      bad++;
      $display("FAIL R7 rd_vld actual=%b/%b expected=%b", rd_vld0, rd_vld1, ev);
    end
    if (ev) begin
      total++;
      if (rd_data0 !== e0[15:0]) begin
        bad++;
        $display("FAIL %s wide rd_data actual=%0h expected=%0h", etag, rd_data0, e0[15:0]);
      end
      total++;
      if (rd_data1 !== e1[5:0]) begin
        bad++;
        $display("FAIL %s narrow rd_data actual=%0h expected=%0h", etag, rd_data1, e1[5:0]);
      end
    end
  endtask

  task automatic step(input bit en, input logic [15:0] zf, input logic [15:0] of,
                      input bit re, input logic [3:0] ad, input string ovr);
    longint inc[7];
    bit     clr[7];
    int     c;
    @(negedge clk);
    check_out();
    enh_mode = en; zero_fix = zf; one_fix = of; rd_en = re; rd_addr = ad;
    for (int k = 0; k < 7; k++) begin inc[k] = 0; clr[k] = 0; end
    for (int d = 0; d < 4; d++) begin
      inc[0] += zf[d*4 +: 4];
      inc[1] += of[d*4 +: 4];
      inc[3+d] = zf[d*4 +: 4] + of[d*4 +: 4];
    end
    inc[2] = inc[0] + inc[1];
    ev = re;
    etag = (ovr != "") ? ovr : tag_of(ad);
    if (re) begin
      c = int'(ad[3:1]);
      if (c > 6) begin e0 = 0; e1 = 0; end
      else if (!ad[0]) begin
        e0 = m0[c] & 65535; h0[c] = m0[c] >> 16;
        e1 = m1[c] & 63;    h1[c] = m1[c] >> 6;
        clr[c] = 1;
      end else begin e0 = h0[c]; e1 = h1[c]; end
    end
    for (int k = 0; k < 7; k++) begin
      longint b0 = clr[k] ? 0 : m0[k];
      longint b1 = clr[k] ? 0 : m1[k];
      if (en) begin b0 += inc[k]; b1 += inc[k]; end
      m0[k] = (b0 > MAX0) ? MAX0 : b0;
      m1[k] = (b1 > MAX1) ? MAX1 : b1;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 7; k++) begin m0[k] = 0; h0[k] = 0; m1[k] = 0; h1[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: read every half with counting off, all zero expected
    for (int a = 0; a < 16; a++) step(0, '0, '0, 1, 4'(a), "R1");
    // R2: mode off, reports ignored; read everything back afterwards
    for (int i = 0; i < 40; i++) step(0, 16'($urandom), 16'($urandom), 0, '0, "R2");
    for (int a = 0; a < 14; a++) step(0, '0, '0, 1, 4'(a), "R2");
    // R8: high word before any low read of a counted value
    step(1, 16'h1234, 16'h4321, 0, '0, "");
    step(0, '0, '0, 1, 4'd1, "R8");
    // mixed random traffic (R3..R9)
    for (int i = 0; i < 3000; i++) begin
      bit re = ($urandom_range(0, 3) == 0);
      step($urandom_range(0, 7) != 0, 16'($urandom), 16'($urandom), re,
           4'($urandom_range(0, 15)), "");
    end
    // R9: low read while counting, with maximal increment in the same cycle
    for (int a = 0; a < 14; a += 2) begin
      step(1, 16'hFFFF, 16'hFFFF, 1, 4'(a), "R9");
      step(0, '0, '0, 1, 4'(a), "R9");
    end
    // R10: drive the narrow instance into saturation and hold it there
    for (int i = 0; i < 120; i++) step(1, 16'hFFFF, 16'hFFFF, 0, '0, "R10");
    for (int a = 0; a < 14; a += 2) begin
      step(1, 16'hFFFF, 16'hFFFF, 1, 4'(a), "R10");
      step(1, 16'hFFFF, 16'hFFFF, 1, 4'(a + 1), "R10");
    end
    for (int i = 0; i < 1000; i++)
      step(1, 16'($urandom), 16'($urandom), ($urandom_range(0, 9) == 0),
           4'($urandom_range(0, 15)), "");
    for (int a = 0; a < 16; a++) step(0, '0, '0, 1, 4'(a), "");
    step(0, '0, '0, 0, '0, "");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule